// File: doc/BRIEF.md
# SQE Heartbeat Pulse Generator

This block produces the signal-quality-error test pulse that a 10 Mb/s twisted-pair transceiver returns to its MAC after every transmitted frame. It watches the MAC transmit-enable input. When transmit enable falls, the block waits a fixed delay and then raises the collision output for a fixed width. The delay and the width are both derived at elaboration time from the clock frequency. Their nominal values are 1 µs each.

The collision output is the OR of the real collision indication and the heartbeat pulse, so the block sits directly in the collision path to the MAC. The heartbeat is produced only when the link runs at 10 Mb/s, repeater mode is off and the disable control is clear. If any of these conditions is lost, a sequence in progress is abandoned. A new transmission starting during a sequence also cancels it.

Top module: `sqe_heartbeat_gen`

## Requirements
- R1: A heartbeat sequence starts on each falling edge of `tx_en_i`, detected on the first clock edge that samples it low after a high sample, provided the block is armed. Armed means `ten_mbps_i`=1, `repeater_i`=0 and `sqe_off_i`=0.
- R2: `col_o` rises on the DELAY-th clock edge after the edge that detected the fall. DELAY = round(CLK_FREQ_HZ·DELAY_NS/1e9) cycles.
- R3: Once risen, the heartbeat holds `col_o` high for exactly WIDTH = round(CLK_FREQ_HZ·WIDTH_NS/1e9) cycles and then releases it.
- R4: With `ten_mbps_i`=0 (100 Mb/s), no heartbeat is produced.
- R5: With `sqe_off_i`=1, no heartbeat is produced.
- R6: With `repeater_i`=1, no heartbeat is produced, whatever the state of the other controls.
- R7: A DELAY or WIDTH count that rounds to zero is raised to one cycle.
- R8: `col_o` is the OR of `col_i` and the heartbeat. `col_i` reaches `col_o` without a register. After reset `col_o` equals `col_i`.
- R9: If `tx_en_i` is sampled high while a heartbeat is waiting or active, the heartbeat is cancelled on that edge, and `col_o` follows `col_i` only.
- R10: If the block is disarmed part-way through a sequence, the sequence aborts on the next edge. Re-arming it does not resume the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | MAC transmit enable |
| col_i | input | 1 | Real collision indication |
| ten_mbps_i | input | 1 | 1 = 10 Mb/s mode, 0 = 100 Mb/s |
| repeater_i | input | 1 | 1 = repeater mode, forces the heartbeat off |
| sqe_off_i | input | 1 | 1 = heartbeat disabled |
| col_o | output | 1 | Collision signal to the MAC |

## Verification
The bench builds two instances from the same stimulus.

The first instance uses a 50 MHz clock with 1000 ns delay and width. Both counts come out to exactly 50 cycles. This gives room to cancel or abort a sequence deep inside its delay phase and inside its pulse phase.

The second instance uses CLK_FREQ_HZ = 300 kHz. Both counts then round to zero and are clamped to one cycle. This covers the one-cycle edge case of the counters.

// File: rtl/sqe_hb_pkg.sv
package sqe_hb_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_e;

  // Nanoseconds to whole clock cycles, rounded to nearest, never below one.
  function automatic int unsigned ns_to_cycles(int unsigned f_hz, int unsigned ns);
    longint unsigned c;
    c = (64'(f_hz) * 64'(ns) + 64'd500_000_000) / 64'd1_000_000_000;
    return (c == 64'd0) ? 32'd1 : 32'(c);
  endfunction

endpackage

// File: rtl/sqe_hb_fall_det.sv
module sqe_hb_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);

  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;

  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) fall_o |=> !fall_o); // R1

endmodule

// File: rtl/sqe_hb_seq.sv
module sqe_hb_seq
  import sqe_hb_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 50,
  parameter int unsigned WIDTH_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic start_i,
  input  logic tx_en_i,
  output logic hb_o
);

  localparam int unsigned MAX_CYC = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] W_LAST = CNT_W'(WIDTH_CYC - 1);

  hb_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HB_IDLE;
      cnt_q   <= '0;
    end else if (!armed_i || tx_en_i) begin
      // disarm or new transmission: drop any pending heartbeat
      state_q <= HB_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        HB_IDLE: begin
          cnt_q <= '0;
          if (start_i) state_q <= HB_WAIT;
        end
        HB_WAIT: begin
          if (cnt_q == D_LAST) begin
            state_q <= HB_PULSE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HB_PULSE: begin
          if (cnt_q == W_LAST) begin
            state_q <= HB_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= HB_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign hb_o = (state_q == HB_PULSE);

  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HB_WAIT) |-> (cnt_q <= D_LAST)); // R2
  AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HB_PULSE) |-> (cnt_q <= W_LAST)); // R3
  AST_PULSE_FROM_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hb_o) |-> $past(state_q == HB_WAIT)); // R2
  AST_DISARM_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> (state_q == HB_IDLE)); // R10

endmodule

// File: rtl/sqe_heartbeat_gen.sv
module sqe_heartbeat_gen
  import sqe_hb_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned DELAY_NS    = 1000,
  parameter int unsigned WIDTH_NS    = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic col_i,
  input  logic ten_mbps_i,
  input  logic repeater_i,
  input  logic sqe_off_i,
  output logic col_o
);

  localparam int unsigned DELAY_CYC = ns_to_cycles(CLK_FREQ_HZ, DELAY_NS);
  localparam int unsigned WIDTH_CYC = ns_to_cycles(CLK_FREQ_HZ, WIDTH_NS);

  logic armed;
  logic tx_fall;
  logic hb;

  assign armed = ten_mbps_i & ~repeater_i & ~sqe_off_i;

  sqe_hb_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (tx_en_i),
    .fall_o (tx_fall)
  );

  sqe_hb_seq #(
    .DELAY_CYC (DELAY_CYC),
    .WIDTH_CYC (WIDTH_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed),
    .start_i (tx_fall),
    .tx_en_i (tx_en_i),
    .hb_o    (hb)
  );

  assign col_o = col_i | hb;

  AST_COL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_i |-> col_o); // R8
  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> (col_o == col_i)); // R4 R5 R6
  AST_TX_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |=> (col_o == col_i)); // R9
  AST_MIN_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DELAY_CYC >= 1) && (WIDTH_CYC >= 1) && (col_o || !col_o)); // R7

endmodule

// File: tb/sqe_heartbeat_gen_test.sv
module sqe_heartbeat_gen_test;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_en = 1'b0, col_in = 1'b0, ten = 1'b1, rep = 1'b0, off = 1'b0;
  logic col_o, col_min_o;
  int   n_chk = 0, n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  sqe_heartbeat_gen #(.CLK_FREQ_HZ(50_000_000), .DELAY_NS(1000), .WIDTH_NS(1000)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .col_i(col_in),
    .ten_mbps_i(ten), .repeater_i(rep), .sqe_off_i(off), .col_o(col_o));

  sqe_heartbeat_gen #(.CLK_FREQ_HZ(300_000), .DELAY_NS(1000), .WIDTH_NS(1000)) uut_min (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .col_i(col_in),
    .ten_mbps_i(ten), .repeater_i(rep), .sqe_off_i(off), .col_o(col_min_o));

  typedef struct packed {
    logic        ten, rep, off;
    logic [15:0] first, width, mfirst, mwidth;
  } vec_t;

  // first = edge index (1 = edge detecting the fall) after which col_o is first high; 0 = never
  localparam vec_t VECS [5] = '{
    '{1'b1, 1'b0, 1'b0, 16'd51, 16'd50, 16'd2, 16'd1}, // R1 R2 R3 R7 armed
    '{1'b0, 1'b0, 1'b0, 16'd0,  16'd0,  16'd0, 16'd0}, // R4 100 Mb/s
    '{1'b1, 1'b0, 1'b1, 16'd0,  16'd0,  16'd0, 16'd0}, // R5 disabled
    '{1'b1, 1'b1, 1'b0, 16'd0,  16'd0,  16'd0, 16'd0}, // R6 repeater
    '{1'b0, 1'b1, 1'b1, 16'd0,  16'd0,  16'd0, 16'd0}  // R6 all off
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_tx();
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drop tx_en at a negedge, then watch n edges, sampling at each negedge
  task automatic drop_and_measure(input int n, output int first, output int width,
                                  output int mfirst, output int mwidth);
    first = 0; width = 0; mfirst = 0; mwidth = 0;
    tx_en = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (col_o) begin
        if (first == 0) first = i;
        width++;
      end
      if (col_min_o) begin
        if (mfirst == 0) mfirst = i;
        mwidth++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int f, w, mf, mw, hi;
    repeat (3) @(negedge clk);
    chk("reset R8 col_o", int'(col_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("post-reset R8 col_o", int'(col_o), 0);

    // table walk
    for (int v = 0; v < 5; v++) begin
      ten = VECS[v].ten; rep = VECS[v].rep; off = VECS[v].off;
      idle_tx();
      drop_and_measure(120, f, w, mf, mw);
      chk($sformatf("row %0d R1 R2 R4 R5 R6 first", v), f, int'(VECS[v].first));
      chk($sformatf("row %0d R3 width", v), w, int'(VECS[v].width));
      chk($sformatf("row %0d R7 min first", v), mf, int'(VECS[v].mfirst));
      chk($sformatf("row %0d R7 min width", v), mw, int'(VECS[v].mwidth));
    end
    ten = 1'b1; rep = 1'b0; off = 1'b0;

    // R8: real collision passes straight through, with and without pulse
    col_in = 1'b1;
    #2;
    chk("R8 col_i passthrough", int'(col_o), 1);
    idle_tx();
    drop_and_measure(120, f, w, mf, mw);
    chk("R8 col_o with col_i held", w, 120);
    col_in = 1'b0;
    #2;
    chk("R8 col_i release", int'(col_o), 0);

    // R9: cancel during delay phase
    idle_tx();
    drop_and_measure(20, f, w, mf, mw);
    tx_en = 1'b1;
    hi = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (col_o) hi++;
    end
    chk("R9 cancel in delay", hi, 0);

    // R9: cancel during pulse phase
    drop_and_measure(60, f, w, mf, mw);
    chk("R9 pulse active before cancel", int'(col_o), 1);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R9 cancel in pulse", int'(col_o), 0);

    // R10: disable mid-pulse aborts, re-enable does not resume
    idle_tx();
    drop_and_measure(55, f, w, mf, mw);
    chk("R10 pulse active before abort", int'(col_o), 1);
    off = 1'b1;
    @(negedge clk);
    chk("R10 abort next edge", int'(col_o), 0);
    off = 1'b0;
    hi = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (col_o) hi++;
    end
    chk("R10 no resume after re-enable", hi, 0);

    // R10: speed change during delay aborts, restoring speed does not resume
    idle_tx();
    drop_and_measure(10, f, w, mf, mw);
    ten = 1'b0;
    @(negedge clk);
    ten = 1'b1;
    hi = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (col_o) hi++;
    end
    chk("R10 speed change abort", hi, 0);

    // R1: a fresh frame after all that still yields a full heartbeat
    idle_tx();
    drop_and_measure(120, f, w, mf, mw);
    chk("R1 R2 recovery first", f, 51);
    chk("R3 recovery width", w, 50);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule